// File: doc/BRIEF.md
# Test access port controller with two-bit instruction decode

This block is the serial test port of a device. It runs the standard sixteen-state test access port state machine. The machine is clocked by the test clock and steered by the mode input. A two-bit instruction register is loaded serially through the data input. The current instruction is then decoded into three results:

- which test data register sits between the serial input and the serial output;
- whether the core is cut off from the pins;
- the capture, shift and update strobes for an external boundary-scan chain.

Only two test data registers exist. One is the boundary-scan chain, which lies outside this block and returns its serial output on `bsr_tdo_i`. The other is a one-bit bypass register inside the block.

There are three instructions. Code 00 drives the pins from the scan cells. Codes 01 and 10 both give a non-intrusive sample/preload. Code 11 bypasses the device. Any reset makes the bypass instruction current. The serial output is retimed on the falling edge of the test clock, and its enable is high only while shifting.

Top module: `tap_ctrl_top`

## Requirements
- R1: While `rst_ni` is low, the controller is held in Test-Logic-Reset, `ir_o` is 11, `tdo_o` is 0 and `tdo_en_o` is 0.
- R2: Five consecutive rising edges of `tck_i` with `tms_i` high bring the controller to Test-Logic-Reset from any state.
- R3: State changes on rising `tck_i` follow the standard sixteen-state transition graph. The graph is visible through the strobes, the output enable and the serial data.
- R4: In Capture-IR the instruction shift stage loads 01 (bit 0 = 1). It is shifted out bit 0 first, so the first bit out of Shift-IR is 1 and the second is 0.
- R5: In Shift-IR, `tdi_i` enters bit 1 and bit 0 leaves toward `tdo_o`. `ir_o` takes the shifted value on the falling edge of `tck_i` while in Update-IR. At no other time does `ir_o` change, except for reset.
- R6: With `ir_o` = 00, `bsr_select_o` = 1 and `test_mode_o` = 1.
- R7: With `ir_o` = 01 or 10, `bsr_select_o` = 1 and `test_mode_o` = 0.
- R8: With `ir_o` = 11, `bsr_select_o` = 0 and `test_mode_o` = 0. In Shift-DR the bypass bit is the data source. It loads 0 in Capture-DR and delays `tdi_i` by one clock.
- R9: Every entry into Test-Logic-Reset sets `ir_o` to 11 at the next falling edge of `tck_i`.
- R10: `tdo_o` and `tdo_en_o` change only on the falling edge of `tck_i`.
  - `tdo_en_o` is 1 only after a falling edge in Shift-IR or Shift-DR.
  - `tdo_o` is bit 0 of the instruction stage in Shift-IR. In Shift-DR it is `bsr_tdo_i` when the chain is selected and the bypass bit otherwise.
  - `tdo_o` is 0 in all other states.
- R11: `bsr_capture_o`, `bsr_shift_o` and `bsr_update_o` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while `bsr_select_o` is 1. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in, sampled on rising `tck_i` |
| bsr_tdo_i | input | 1 | Serial output of the external boundary-scan chain |
| tdo_o | output | 1 | Serial data out, changes on falling `tck_i` |
| tdo_en_o | output | 1 | Output enable for `tdo_o` |
| ir_o | output | 2 | Current instruction |
| bsr_select_o | output | 1 | Boundary-scan chain is the selected data register |
| test_mode_o | output | 1 | Core isolated, pins driven from the scan cells |
| bsr_capture_o | output | 1 | Capture strobe for the chain |
| bsr_shift_o | output | 1 | Shift strobe for the chain |
| bsr_update_o | output | 1 | Update strobe for the chain |

## Verification
State, instruction-stage and bypass updates happen on the rising edge that samples `tms_i` and `tdi_i`. The strobes follow at once, as decodes of that new state. `ir_o`, `tdo_o` and `tdo_en_o` follow half a clock later, on the next falling edge, which is based on the state present at that edge.

The bench drives inputs 1 ns after each falling edge and samples 3 ns after it. At that point the previous rising edge and the current falling edge have both taken effect. A bench model applies the falling-edge effects first and the rising-edge effects after the sample, so each expected value lines up with the cycle in which it is due.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    ST_RESET   = 4'h0,
    ST_IDLE    = 4'h1,
    ST_SEL_DR  = 4'h2,
    ST_CAP_DR  = 4'h3,
    ST_SH_DR   = 4'h4,
    ST_EX1_DR  = 4'h5,
    ST_PAU_DR  = 4'h6,
    ST_EX2_DR  = 4'h7,
    ST_UPD_DR  = 4'h8,
    ST_SEL_IR  = 4'h9,
    ST_CAP_IR  = 4'hA,
    ST_SH_IR   = 4'hB,
    ST_EX1_IR  = 4'hC,
    ST_PAU_IR  = 4'hD,
    ST_EX2_IR  = 4'hE,
    ST_UPD_IR  = 4'hF
  } tap_state_e;

  localparam int unsigned IR_W = 2;
  typedef logic [IR_W-1:0] instr_t;

  localparam instr_t INSTR_EXTEST  = 2'b00;
  localparam instr_t INSTR_SAMPLE0 = 2'b01;
  localparam instr_t INSTR_SAMPLE1 = 2'b10;
  localparam instr_t INSTR_BYPASS  = 2'b11;
  localparam instr_t IR_CAPTURE    = 2'b01;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms_i ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int unsigned W          = IR_W,
  parameter logic [W-1:0] CAPT_VAL  = IR_CAPTURE,
  parameter logic [W-1:0] RESET_VAL = INSTR_BYPASS
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         tdi_i,
  input  tap_state_e   state_i,
  output logic         sr_lsb_o,
  output logic [W-1:0] ir_o
);
  logic [W-1:0] sr_q, ir_q;

  // shift stage on the rising edge
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= CAPT_VAL;
    end else if (state_i == ST_CAP_IR) begin
      sr_q <= CAPT_VAL;
    end else if (state_i == ST_SH_IR) begin
      if (W > 1) sr_q <= {tdi_i, sr_q[W-1:1]};
      else       sr_q <= tdi_i;
    end
  end

  // update stage on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                     ir_q <= RESET_VAL;
    else if (state_i == ST_RESET)    ir_q <= RESET_VAL;
    else if (state_i == ST_UPD_IR)   ir_q <= sr_q;
  end

  assign sr_lsb_o = sr_q[0];
  assign ir_o     = ir_q;
endmodule

// File: rtl/tap_bypass.sv
module tap_bypass
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  output logic       byp_o
);
  logic byp_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   byp_q <= 1'b0;
    else if (state_i == ST_CAP_DR) byp_q <= 1'b0;
    else if (state_i == ST_SH_DR)  byp_q <= tdi_i;
  end

  assign byp_o = byp_q;
endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_pkg::*;
(
  input  instr_t     ir_i,
  input  tap_state_e state_i,
  output logic       bsr_select_o,
  output logic       test_mode_o,
  output logic       bsr_capture_o,
  output logic       bsr_shift_o,
  output logic       bsr_update_o
);
  always_comb begin
    unique case (ir_i)
      INSTR_EXTEST:                begin bsr_select_o = 1'b1; test_mode_o = 1'b1; end
      INSTR_SAMPLE0, INSTR_SAMPLE1: begin bsr_select_o = 1'b1; test_mode_o = 1'b0; end
      default:                     begin bsr_select_o = 1'b0; test_mode_o = 1'b0; end
    endcase
  end

  assign bsr_capture_o = bsr_select_o && (state_i == ST_CAP_DR);
  assign bsr_shift_o   = bsr_select_o && (state_i == ST_SH_DR);
  assign bsr_update_o  = bsr_select_o && (state_i == ST_UPD_DR);
endmodule

// File: rtl/tap_ctrl_top.sv
module tap_ctrl_top
  import tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tms_i,
  input  logic            tdi_i,
  input  logic            bsr_tdo_i,
  output logic            tdo_o,
  output logic            tdo_en_o,
  output logic [IR_W-1:0] ir_o,
  output logic            bsr_select_o,
  output logic            test_mode_o,
  output logic            bsr_capture_o,
  output logic            bsr_shift_o,
  output logic            bsr_update_o
);
  tap_state_e state;
  logic       ir_lsb, byp, bsr_sel;
  instr_t     ir_cur;
  logic       tdo_q, tdo_en_q, tdo_d;

  tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(state)
  );

  tap_ir u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tdi_i   (tdi_i),
    .state_i (state),
    .sr_lsb_o(ir_lsb),
    .ir_o    (ir_cur)
  );

  tap_bypass u_byp (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tdi_i  (tdi_i),
    .state_i(state),
    .byp_o  (byp)
  );

  tap_decode u_dec (
    .ir_i         (ir_cur),
    .state_i      (state),
    .bsr_select_o (bsr_sel),
    .test_mode_o  (test_mode_o),
    .bsr_capture_o(bsr_capture_o),
    .bsr_shift_o  (bsr_shift_o),
    .bsr_update_o (bsr_update_o)
  );

  always_comb begin
    unique case (state)
      ST_SH_IR: tdo_d = ir_lsb;
      ST_SH_DR: tdo_d = bsr_sel ? bsr_tdo_i : byp;
      default:  tdo_d = 1'b0;
    endcase
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  assign tdo_o        = tdo_q;
  assign tdo_en_o     = tdo_en_q;
  assign ir_o         = ir_cur;
  assign bsr_select_o = bsr_sel;
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input tap_state_e      state_i,
  input logic [IR_W-1:0] ir_i,
  input logic            tdo_en_i,
  input logic            test_mode_i,
  input logic            bsr_select_i,
  input logic            cap_i,
  input logic            sh_i,
  input logic            upd_i
);
  logic [2:0] hi_cnt;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (!tms_i)    hi_cnt <= '0;
    else if (hi_cnt < 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_five_high_reset_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (hi_cnt == 3'd5) |-> (state_i == ST_RESET));

  assert_tdo_en_shift_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_i == ((state_i == ST_SH_IR) || (state_i == ST_SH_DR)));

  assert_ir_hold_R5: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !((state_i == ST_UPD_IR) || (state_i == ST_RESET)) |=> $stable(ir_i));

  assert_reset_bypass_R9: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (state_i == ST_RESET) |=> (ir_i == INSTR_BYPASS));

  assert_extest_selects_bsr_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    test_mode_i |-> bsr_select_i);

  assert_strobe_onehot_R11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({cap_i, sh_i, upd_i}));

  assert_strobe_needs_bsr_R11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap_i || sh_i || upd_i) |-> bsr_select_i);
endmodule

bind tap_ctrl_top tap_ctrl_chk u_chk (
  .tck_i       (tck_i),
  .rst_ni      (rst_ni),
  .tms_i       (tms_i),
  .state_i     (state),
  .ir_i        (ir_o),
  .tdo_en_i    (tdo_en_o),
  .test_mode_i (test_mode_o),
  .bsr_select_i(bsr_select_o),
  .cap_i       (bsr_capture_o),
  .sh_i        (bsr_shift_o),
  .upd_i       (bsr_update_o)
);

// File: tb/tap_ctrl_top_test.sv
module tap_ctrl_top_test;
  import tap_pkg::*;

  logic tck_i = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0, bsr_tdo_i = 1'b0;
  logic tdo_o, tdo_en_o, bsr_select_o, test_mode_o;
  logic bsr_capture_o, bsr_shift_o, bsr_update_o;
  logic [1:0] ir_o;

  int checks = 0, errors = 0;
  bit done = 0;

  tap_state_e m_s;
  logic [1:0] m_sr, m_ir;
  logic       m_byp;

  always #4 tck_i = ~tck_i;

  tap_ctrl_top uut (.*);

  function automatic tap_state_e nxt(tap_state_e s, logic t);
    case (s)
      ST_RESET:  return t ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return t ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return t ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR, ST_SH_DR: return t ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return t ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return t ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return t ? ST_UPD_DR : ST_SH_DR;
      ST_SEL_IR: return t ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR, ST_SH_IR: return t ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return t ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return t ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return t ? ST_UPD_IR : ST_SH_IR;
      default:   return t ? ST_SEL_DR : ST_IDLE;  // both update states
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s = ST_RESET; m_sr = 2'b01; m_ir = 2'b11; m_byp = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge tck_i); #1 rst_ni = 1'b0;
    model_reset();
    #2;
    chk("R1 ir", {2'b0, ir_o}, 4'h3);
    chk("R1 tdo", {2'b0, tdo_o, tdo_en_o}, 4'h0);
    @(posedge tck_i); #2 rst_ni = 1'b1;
  endtask

  task automatic step(input logic tms, input logic tdi, input logic bsr);
    logic e_en, e_tdo, e_sel, e_tm;
    string tg;
    @(negedge tck_i); #1;
    if (m_s == ST_UPD_IR) m_ir = m_sr;
    if (m_s == ST_RESET)  m_ir = 2'b11;
    e_en  = (m_s == ST_SH_IR) || (m_s == ST_SH_DR);
    e_sel = (m_ir != 2'b11);
    e_tm  = (m_ir == 2'b00);
    if (m_s == ST_SH_IR)      e_tdo = m_sr[0];
    else if (m_s == ST_SH_DR) e_tdo = e_sel ? bsr_tdo_i : m_byp;
    else                      e_tdo = 1'b0;
    tms_i = tms; tdi_i = tdi; bsr_tdo_i = bsr;
    #2;
    chk((m_s == ST_RESET) ? "R2 R9 ir" : "R5 ir", {2'b0, ir_o}, {2'b0, m_ir});
    tg = (m_ir == 2'b00) ? "R6 decode" : (m_ir == 2'b11) ? "R8 decode" : "R7 decode";
    chk(tg, {2'b0, bsr_select_o, test_mode_o}, {2'b0, e_sel, e_tm});
    chk("R3 R11 strobes", {1'b0, bsr_capture_o, bsr_shift_o, bsr_update_o},
        {1'b0, e_sel && m_s == ST_CAP_DR, e_sel && m_s == ST_SH_DR, e_sel && m_s == ST_UPD_DR});
    if (m_s == ST_SH_IR)                 tg = "R4 R10 tdo";
    else if (m_s == ST_SH_DR && !e_sel)  tg = "R8 R10 tdo";
    else                                 tg = "R10 tdo";
    chk(tg, {2'b0, tdo_en_o, tdo_o}, {2'b0, e_en, e_tdo});
    unique case (m_s)
      ST_CAP_IR: m_sr = 2'b01;
      ST_SH_IR:  m_sr = {tdi, m_sr[1]};
      ST_CAP_DR: m_byp = 1'b0;
      ST_SH_DR:  m_byp = tdi;
      default: ;
    endcase
    m_s = nxt(m_s, tms);
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [1:0] code);
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(0, code[0], 0); step(1, code[1], 0); step(1, 0, 0); step(0, 0, 0);
    step(0, 0, 0);
  endtask

  task automatic shift_dr(input int n);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, 1'($urandom), 1'($urandom));
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    do_reset();
    to_idle();
    for (int c = 0; c < 4; c++) begin
      load_ir(2'(c));
      shift_dr(6);
      chk("R5 loaded code", {2'b0, ir_o}, 4'(c));
    end
    load_ir(2'b00);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R2 R9 five-high", {2'b0, ir_o}, 4'h3);
    for (int i = 0; i < 4000; i++)
      step($urandom_range(9) < 3, 1'($urandom), 1'($urandom));
    load_ir(2'b10);
    do_reset();
    chk("R1 R9 async", {2'b0, ir_o}, 4'h3);
    for (int i = 0; i < 2000; i++)
      step($urandom_range(9) < 3, 1'($urandom), 1'($urandom));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule